// File: doc/BRIEF.md
# Context-Switch Timeout Monitor

This block watches every engine's context-switch handshake. Each engine runs its own timer that starts when a context request is issued and stops when the engine acknowledges. When the programmed period runs out first, the block sets that engine's pending bit. In the same cycle it freezes a snapshot of the request that timed out: the switch phase and the outgoing and incoming task-group IDs. One summary interrupt, with its own enable, is raised while any pending bit is set.

The snapshot stays fixed while the pending bit is set. A separate status field keeps moving in that time. It records whether the late ack finally came, whether the engine was reset first, and whether a later request on the same engine also timed out. No details of that later timeout are kept. Software clears a pending bit by writing a one to it, and this re-arms capture for that engine. It reads one engine's snapshot and status at a time through a select input.

Top module: `cswto_monitor`

## Requirements
- R1: Reset leaves every pending bit clear, the interrupt low, detection disabled and the period at 0. `cfg_wr` loads period and enable together, and they read back on `cfg_period_rd`/`cfg_enable_rd`. While detection is disabled, no pending bit becomes set.
- R2: Take a request sampled at clock edge 0 with period P. If it is not acked, its engine's pending bit reads set after edge P+1 and reads clear after edge P. An ack before that point prevents the timeout. One request times out at most once.
- R3: A one in `clr_mask` clears that engine's pending bit. A zero bit has no effect, and an all-ones write clears every bit.
- R4: `irq` is high exactly when `irq_en` is high and at least one pending bit is set.
- R5: At capture the block stores the phase of the timed-out request (load=1, save=2, switch=3) and its previous and next task-group IDs. These can be read for the engine chosen by `info_sel`. They do not change while the pending bit stays set, even when new requests arrive.
- R6: Status (2-bit code) is AWAITING_ACK=0 at capture. It becomes ACK_RECEIVED=2 when that engine later acks.
- R7: While pending, a further timeout moves status from ACK_RECEIVED or ENG_WAS_RESET to DROPPED_TIMEOUT=3. The snapshot is left unchanged.
- R8: An engine reset while status is AWAITING_ACK gives ENG_WAS_RESET=1. A later ack then gives ACK_RECEIVED. The reset also cancels the engine's running timer.
- R9: After a clear, the next timeout takes a fresh snapshot. A timeout in the same cycle as a clear of that bit wins: the bit stays set with the new snapshot and status 0.
- R10: A timeout in the save phase, then its ack, then a load request for the same switch reports ACK_RECEIVED while the load runs. The phase stays save.
- R11: An ack, engine reset or new request in the cycle where a timeout would fire suppresses that timeout. A request and an ack in the same cycle start the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load period and enable |
| cfg_period | input | PERIOD_W | Timeout period in cycles |
| cfg_enable | input | 1 | Detection enable |
| irq_en | input | 1 | Summary interrupt enable |
| clr_mask | input | NUM_ENG | Write-1-to-clear pending bits |
| eng_req | input | NUM_ENG | Context request strobe per engine |
| eng_phase | input | 2*NUM_ENG | Phase of each request (load=1, save=2, switch=3) |
| eng_prev_id | input | ID_W*NUM_ENG | Outgoing task-group ID per engine |
| eng_next_id | input | ID_W*NUM_ENG | Incoming task-group ID per engine |
| eng_ack | input | NUM_ENG | Context acknowledge per engine |
| eng_reset | input | NUM_ENG | Engine reset strobe |
| info_sel | input | SEL_W | Engine whose snapshot is read |
| cfg_period_rd | output | PERIOD_W | Period readback |
| cfg_enable_rd | output | 1 | Enable readback |
| pend_mask | output | NUM_ENG | Pending timeout bits |
| irq | output | 1 | Summary timeout interrupt |
| info_phase | output | 2 | Captured phase of selected engine |
| info_prev_id | output | ID_W | Captured previous ID |
| info_next_id | output | ID_W | Captured next ID |
| info_status | output | 2 | Live status of selected engine |

## Verification
The sharpest collision is a software clear landing in the very cycle a fresh timeout fires on the same engine. The bench sets this up by counting a second request out to its exact timeout edge and pulsing the clear on that edge. It then expects the bit still set, status 0 and the new IDs. A second collision is an ack arriving on the edge where the period would expire, which must leave the bit clear. The random phase throws both kinds of overlap at a cycle model many times over.

// File: rtl/cswto_pkg.sv
package cswto_pkg;

    typedef enum logic [1:0] {
        ST_AWAIT   = 2'd0,
        ST_ENGRST  = 2'd1,
        ST_ACKED   = 2'd2,
        ST_DROPPED = 2'd3
    } tmo_status_e;

    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_SAVE   = 2'd2,
        PH_SWITCH = 2'd3
    } sw_phase_e;

    // Live status update while a pending bit is held.
    function automatic tmo_status_e status_next(tmo_status_e cur, logic tmo,
                                                logic ack, logic erst);
        tmo_status_e n;
        n = cur;
        if (tmo && (cur == ST_ACKED || cur == ST_ENGRST))
            n = ST_DROPPED;
        else if (ack && (cur == ST_AWAIT || cur == ST_ENGRST))
            n = ST_ACKED;
        else if (erst && cur == ST_AWAIT)
            n = ST_ENGRST;
        return n;
    endfunction

endpackage

// File: rtl/cswto_timer.sv
module cswto_timer
    import cswto_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int ID_W     = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                req_i,
    input  sw_phase_e           req_phase_i,
    input  logic [ID_W-1:0]     req_prev_i,
    input  logic [ID_W-1:0]     req_next_i,
    input  logic                ack_i,
    input  logic                erst_i,
    output logic                tmo_o,
    output sw_phase_e           cur_phase_o,
    output logic [ID_W-1:0]     cur_prev_o,
    output logic [ID_W-1:0]     cur_next_o
);

    logic                busy_q;
    logic                expired_q;
    logic [PERIOD_W-1:0] cnt_q;

    assign tmo_o = busy_q && !expired_q && en_i && !ack_i && !erst_i && !req_i
                   && (cnt_q >= period_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            expired_q   <= 1'b0;
            cnt_q       <= '0;
            cur_phase_o <= PH_NONE;
            cur_prev_o  <= '0;
            cur_next_o  <= '0;
        end else if (req_i) begin
            busy_q      <= 1'b1;
            expired_q   <= 1'b0;
            cnt_q       <= '0;
            cur_phase_o <= req_phase_i;
            cur_prev_o  <= req_prev_i;
            cur_next_o  <= req_next_i;
        end else if (ack_i || erst_i) begin
            busy_q    <= 1'b0;
            expired_q <= 1'b0;
        end else begin
            if (tmo_o)
                expired_q <= 1'b1;
            if (busy_q && !expired_q && cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    once_per_req_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_o |=> !tmo_o);

    // R11
    ack_cancels_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !req_i) |=> !tmo_o);

endmodule

// File: rtl/cswto_capture.sv
module cswto_capture
    import cswto_pkg::*;
#(
    parameter int ID_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tmo_i,
    input  logic            ack_i,
    input  logic            erst_i,
    input  logic            clr_i,
    input  sw_phase_e       snap_phase_i,
    input  logic [ID_W-1:0] snap_prev_i,
    input  logic [ID_W-1:0] snap_next_i,
    output logic            pend_o,
    output sw_phase_e       phase_o,
    output logic [ID_W-1:0] prev_o,
    output logic [ID_W-1:0] next_o,
    output tmo_status_e     status_o
);

    typedef struct packed {
        sw_phase_e       phase;
        logic [ID_W-1:0] prev;
        logic [ID_W-1:0] next;
    } snap_t;

    snap_t       snap_q;
    logic        pend_q;
    tmo_status_e status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            status_q <= ST_AWAIT;
            snap_q   <= '0;
        end else if (tmo_i && (!pend_q || clr_i)) begin
            pend_q   <= 1'b1;
            status_q <= ST_AWAIT;
            snap_q   <= '{phase: snap_phase_i, prev: snap_prev_i, next: snap_next_i};
        end else if (pend_q && clr_i) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            status_q <= status_next(status_q, tmo_i, ack_i, erst_i);
        end
    end

    assign pend_o   = pend_q;
    assign phase_o  = snap_q.phase;
    assign prev_o   = snap_q.prev;
    assign next_o   = snap_q.next;
    assign status_o = status_q;

    // R5
    snap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> $stable(snap_q));

    // R6
    capture_await_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_i && !pend_q) |=> (pend_q && status_q == ST_AWAIT));

    // R6
    ack_received_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i && ack_i && status_q == ST_AWAIT) |=> status_q == ST_ACKED);

    // R7
    no_early_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i && status_q == ST_AWAIT) |=> status_q != ST_DROPPED);

endmodule

// File: rtl/cswto_monitor.sv
module cswto_monitor
    import cswto_pkg::*;
#(
    parameter  int NUM_ENG  = 4,
    parameter  int ID_W     = 12,
    parameter  int PERIOD_W = 16,
    localparam int SEL_W    = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [PERIOD_W-1:0]     cfg_period,
    input  logic                    cfg_enable,
    input  logic                    irq_en,
    input  logic [NUM_ENG-1:0]      clr_mask,
    input  logic [NUM_ENG-1:0]      eng_req,
    input  logic [2*NUM_ENG-1:0]    eng_phase,
    input  logic [ID_W*NUM_ENG-1:0] eng_prev_id,
    input  logic [ID_W*NUM_ENG-1:0] eng_next_id,
    input  logic [NUM_ENG-1:0]      eng_ack,
    input  logic [NUM_ENG-1:0]      eng_reset,
    input  logic [SEL_W-1:0]        info_sel,
    output logic [PERIOD_W-1:0]     cfg_period_rd,
    output logic                    cfg_enable_rd,
    output logic [NUM_ENG-1:0]      pend_mask,
    output logic                    irq,
    output logic [1:0]              info_phase,
    output logic [ID_W-1:0]         info_prev_id,
    output logic [ID_W-1:0]         info_next_id,
    output logic [1:0]              info_status
);

    logic [PERIOD_W-1:0] period_q;
    logic                enable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            enable_q <= 1'b0;
        end else if (cfg_wr) begin
            period_q <= cfg_period;
            enable_q <= cfg_enable;
        end
    end

    logic [NUM_ENG-1:0] tmo_w;
    logic [NUM_ENG-1:0] pend_w;
    sw_phase_e          cur_phase_w [NUM_ENG];
    logic [ID_W-1:0]    cur_prev_w  [NUM_ENG];
    logic [ID_W-1:0]    cur_next_w  [NUM_ENG];
    sw_phase_e          cap_phase_w [NUM_ENG];
    logic [ID_W-1:0]    cap_prev_w  [NUM_ENG];
    logic [ID_W-1:0]    cap_next_w  [NUM_ENG];
    tmo_status_e        cap_stat_w  [NUM_ENG];

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        cswto_timer #(.PERIOD_W(PERIOD_W), .ID_W(ID_W)) u_timer (
            .clk         (clk),
            .rst         (rst),
            .en_i        (enable_q),
            .period_i    (period_q),
            .req_i       (eng_req[g]),
            .req_phase_i (sw_phase_e'(eng_phase[2*g +: 2])),
            .req_prev_i  (eng_prev_id[ID_W*g +: ID_W]),
            .req_next_i  (eng_next_id[ID_W*g +: ID_W]),
            .ack_i       (eng_ack[g]),
            .erst_i      (eng_reset[g]),
            .tmo_o       (tmo_w[g]),
            .cur_phase_o (cur_phase_w[g]),
            .cur_prev_o  (cur_prev_w[g]),
            .cur_next_o  (cur_next_w[g])
        );

        cswto_capture #(.ID_W(ID_W)) u_capture (
            .clk          (clk),
            .rst          (rst),
            .tmo_i        (tmo_w[g]),
            .ack_i        (eng_ack[g]),
            .erst_i       (eng_reset[g]),
            .clr_i        (clr_mask[g]),
            .snap_phase_i (cur_phase_w[g]),
            .snap_prev_i  (cur_prev_w[g]),
            .snap_next_i  (cur_next_w[g]),
            .pend_o       (pend_w[g]),
            .phase_o      (cap_phase_w[g]),
            .prev_o       (cap_prev_w[g]),
            .next_o       (cap_next_w[g]),
            .status_o     (cap_stat_w[g])
        );

        // R1
        no_set_when_off_chk: assert property (@(posedge clk) disable iff (rst)
            !enable_q |=> !$rose(pend_w[g]));

        // R3
        clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[g] && !tmo_w[g]) |=> !pend_w[g]);
    end

    always_comb begin
        info_phase   = 2'd0;
        info_prev_id = '0;
        info_next_id = '0;
        info_status  = 2'd0;
        for (int i = 0; i < NUM_ENG; i++) begin
            if (info_sel == SEL_W'(i)) begin
                info_phase   = cap_phase_w[i];
                info_prev_id = cap_prev_w[i];
                info_next_id = cap_next_w[i];
                info_status  = cap_stat_w[i];
            end
        end
    end

    assign pend_mask     = pend_w;
    assign irq           = irq_en && (|pend_w);
    assign cfg_period_rd = period_q;
    assign cfg_enable_rd = enable_q;

endmodule

// File: tb/cswto_monitor_tb.sv
module cswto_monitor_tb;

    localparam int NE = 4;
    localparam int IW = 12;
    localparam int PW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_wr = 1'b0;
    logic [PW-1:0]   cfg_period = '0;
    logic            cfg_enable = 1'b0;
    logic            irq_en = 1'b0;
    logic [NE-1:0]   clr_mask = '0;
    logic [NE-1:0]   eng_req = '0;
    logic [2*NE-1:0] eng_phase = '0;
    logic [IW*NE-1:0] eng_prev_id = '0;
    logic [IW*NE-1:0] eng_next_id = '0;
    logic [NE-1:0]   eng_ack = '0;
    logic [NE-1:0]   eng_reset = '0;
    logic [1:0]      info_sel = '0;
    logic [PW-1:0]   cfg_period_rd;
    logic            cfg_enable_rd;
    logic [NE-1:0]   pend_mask;
    logic            irq;
    logic [1:0]      info_phase;
    logic [IW-1:0]   info_prev_id;
    logic [IW-1:0]   info_next_id;
    logic [1:0]      info_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_en; int m_per;
    bit m_busy[NE]; bit m_exp[NE]; int m_cnt[NE];
    int m_cph[NE]; int m_cpv[NE]; int m_cnx[NE];
    bit m_pend[NE]; int m_ph[NE]; int m_pv[NE]; int m_nx[NE]; int m_st[NE];

    always #10 clk = ~clk;

    cswto_monitor #(.NUM_ENG(NE), .ID_W(IW), .PERIOD_W(PW)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .cfg_enable(cfg_enable), .irq_en(irq_en), .clr_mask(clr_mask),
        .eng_req(eng_req), .eng_phase(eng_phase), .eng_prev_id(eng_prev_id),
        .eng_next_id(eng_next_id), .eng_ack(eng_ack), .eng_reset(eng_reset),
        .info_sel(info_sel), .cfg_period_rd(cfg_period_rd),
        .cfg_enable_rd(cfg_enable_rd), .pend_mask(pend_mask), .irq(irq),
        .info_phase(info_phase), .info_prev_id(info_prev_id),
        .info_next_id(info_next_id), .info_status(info_status)
    );

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int model_status(int cur, bit t, bit a, bit r);
        if (t && (cur == 2 || cur == 1)) return 3;
        if (a && (cur == 0 || cur == 1)) return 2;
        if (r && cur == 0) return 1;
        return cur;
    endfunction

    task automatic model_reset();
        m_en = 0; m_per = 0;
        for (int e = 0; e < NE; e++) begin
            m_busy[e] = 0; m_exp[e] = 0; m_cnt[e] = 0;
            m_cph[e] = 0; m_cpv[e] = 0; m_cnx[e] = 0;
            m_pend[e] = 0; m_ph[e] = 0; m_pv[e] = 0; m_nx[e] = 0; m_st[e] = 0;
        end
    endtask

    task automatic model_step();
        for (int e = 0; e < NE; e++) begin
            bit t;
            t = m_busy[e] && !m_exp[e] && m_en && !eng_ack[e] && !eng_reset[e]
                && !eng_req[e] && (m_cnt[e] >= m_per);
            if (t && (!m_pend[e] || clr_mask[e])) begin
                m_pend[e] = 1; m_st[e] = 0;
                m_ph[e] = m_cph[e]; m_pv[e] = m_cpv[e]; m_nx[e] = m_cnx[e];
            end else if (m_pend[e] && clr_mask[e]) begin
                m_pend[e] = 0;
            end else if (m_pend[e]) begin
                m_st[e] = model_status(m_st[e], t, eng_ack[e], eng_reset[e]);
            end
            if (eng_req[e]) begin
                m_busy[e] = 1; m_exp[e] = 0; m_cnt[e] = 0;
                m_cph[e] = int'(eng_phase[2*e +: 2]);
                m_cpv[e] = int'(eng_prev_id[IW*e +: IW]);
                m_cnx[e] = int'(eng_next_id[IW*e +: IW]);
            end else if (eng_ack[e] || eng_reset[e]) begin
                m_busy[e] = 0; m_exp[e] = 0;
            end else begin
                if (m_busy[e] && !m_exp[e] && m_cnt[e] < 65535) m_cnt[e]++;
                if (t) m_exp[e] = 1;
            end
        end
        if (cfg_wr) begin m_en = cfg_enable; m_per = int'(cfg_period); end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        eng_req = '0; eng_ack = '0; eng_reset = '0; clr_mask = '0; cfg_wr = 1'b0;
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic set_req(int e, int ph, int pv, int nx);
        eng_req[e] = 1'b1;
        eng_phase[2*e +: 2] = ph[1:0];
        eng_prev_id[IW*e +: IW] = pv[IW-1:0];
        eng_next_id[IW*e +: IW] = nx[IW-1:0];
    endtask

    task automatic set_cfg(int per, bit en);
        cfg_wr = 1'b1; cfg_period = per[PW-1:0]; cfg_enable = en;
        cycle();
    endtask

    task automatic sel(int e);
        info_sel = e[1:0];
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        model_reset();
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 reset pend", int'(pend_mask), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset enable", int'(cfg_enable_rd), 0);
        chk("R1 reset period", int'(cfg_period_rd), 0);

        // R1 disabled: no timeout
        set_cfg(3, 0);
        chk("R1 period readback", int'(cfg_period_rd), 3);
        set_req(0, 1, 1, 2); cycle();
        cycles(10);
        chk("R1 disabled no pend", int'(pend_mask), 0);
        eng_ack[0] = 1'b1; cycle();

        // R2 timing, R4, R5, R6
        irq_en = 1'b1;
        set_cfg(5, 1);
        chk("R1 enable readback", int'(cfg_enable_rd), 1);
        set_req(1, 3, 'h011, 'h022); cycle();
        cycles(5);
        chk("R2 not before P+1", int'(pend_mask), 0);
        cycle();
        chk("R2 pend at P+1", int'(pend_mask), 2);
        chk("R4 irq on", int'(irq), 1);
        sel(1);
        chk("R5 phase", int'(info_phase), 3);
        chk("R5 prev", int'(info_prev_id), 'h011);
        chk("R5 next", int'(info_next_id), 'h022);
        chk("R6 await", int'(info_status), 0);
        irq_en = 1'b0; #1;
        chk("R4 irq masked", int'(irq), 0);
        irq_en = 1'b1;

        // R6 ack, R7 dropped
        eng_ack[1] = 1'b1; cycle();
        sel(1);
        chk("R6 ack received", int'(info_status), 2);
        set_req(1, 1, 'h033, 'h044); cycle();
        cycles(6);
        sel(1);
        chk("R7 dropped", int'(info_status), 3);
        chk("R7 phase kept", int'(info_phase), 3);
        chk("R7 prev kept", int'(info_prev_id), 'h011);

        // R3 clear
        clr_mask = 4'b0100; cycle();
        chk("R3 zero bit no effect", int'(pend_mask), 2);
        clr_mask = 4'b1111; cycle();
        chk("R3 all ones clears", int'(pend_mask), 0);
        cycles(10);
        chk("R2 once per request", int'(pend_mask), 0);
        eng_ack[1] = 1'b1; cycle();

        // R8 engine reset paths
        set_req(2, 1, 5, 6); cycle();
        cycles(6);
        chk("R8 pend eng2", int'(pend_mask), 4);
        eng_reset[2] = 1'b1; cycle();
        sel(2);
        chk("R8 eng was reset", int'(info_status), 1);
        eng_ack[2] = 1'b1; cycle();
        sel(2);
        chk("R8 ack after reset", int'(info_status), 2);
        clr_mask = 4'b0100; cycle();
        set_req(2, 2, 9, 9); cycle();
        cycles(6);
        eng_reset[2] = 1'b1; cycle();
        set_req(2, 3, 10, 11); cycle();
        cycles(6);
        sel(2);
        chk("R8 timeout after reset drops", int'(info_status), 3);
        chk("R8 snapshot kept", int'(info_prev_id), 9);
        clr_mask = 4'b1111; eng_ack[2] = 1'b1; cycle();
        set_req(3, 1, 1, 1); cycle();
        cycles(2);
        eng_reset[3] = 1'b1; cycle();
        cycles(10);
        chk("R8 reset cancels timer", int'(pend_mask), 0);

        // R9 re-arm and clear/timeout collision
        set_req(0, 1, 'h100, 'h101); cycle();
        cycles(6);
        chk("R9 first capture", int'(pend_mask), 1);
        set_req(0, 3, 'h200, 'h201); cycle();
        cycles(5);
        sel(0);
        chk("R5 frozen across request", int'(info_phase), 1);
        clr_mask[0] = 1'b1; cycle();
        sel(0);
        chk("R9 set wins over clear", int'(pend_mask), 1);
        chk("R9 fresh phase", int'(info_phase), 3);
        chk("R9 fresh prev", int'(info_prev_id), 'h200);
        chk("R9 fresh status", int'(info_status), 0);
        clr_mask = 4'b1111; cycle();

        // R10 save-phase timeout then load of same switch
        set_req(3, 2, 7, 8); cycle();
        cycles(6);
        eng_ack[3] = 1'b1; cycle();
        set_req(3, 1, 7, 8); cycle();
        cycles(2);
        sel(3);
        chk("R10 ack during load", int'(info_status), 2);
        chk("R10 phase save", int'(info_phase), 2);
        clr_mask = 4'b1111; eng_ack = 4'b1111; cycle();

        // R11 same-cycle precedence
        set_cfg(4, 1);
        set_req(0, 1, 3, 3); cycle();
        cycles(4);
        eng_ack[0] = 1'b1; cycle();
        cycles(8);
        chk("R11 ack on expiry edge", int'(pend_mask), 0);
        set_req(0, 1, 4, 4); eng_ack[0] = 1'b1; cycle();
        cycles(5);
        chk("R11 req beats ack", int'(pend_mask), 1);
        clr_mask = 4'b1111; eng_ack = 4'b1111; cycle();

        // random phase against the cycle model
        for (int k = 0; k < 4000; k++) begin
            for (int e = 0; e < NE; e++) begin
                if ($urandom_range(11) == 0)
                    set_req(e, int'($urandom_range(3)), int'($urandom_range(4095)),
                            int'($urandom_range(4095)));
                if ($urandom_range(7) == 0) eng_ack[e] = 1'b1;
                if ($urandom_range(39) == 0) eng_reset[e] = 1'b1;
                if ($urandom_range(15) == 0) clr_mask[e] = 1'b1;
            end
            if ($urandom_range(99) == 0) begin
                cfg_wr = 1'b1;
                cfg_period = PW'($urandom_range(12));
                cfg_enable = ($urandom_range(4) != 0);
            end
            if ($urandom_range(49) == 0) irq_en = ~irq_en;
            cycle();
            begin
                int s;
                int exp_mask;
                bit any;
                s = int'($urandom_range(3));
                exp_mask = 0; any = 0;
                for (int e = 0; e < NE; e++) if (m_pend[e]) begin
                    exp_mask |= (1 << e); any = 1;
                end
                sel(s);
                chk("R2 random pend", int'(pend_mask), exp_mask);
                chk("R4 random irq", int'(irq), int'(irq_en && any));
                chk("R5 random phase", int'(info_phase), m_ph[s]);
                chk("R5 random ids", int'(info_prev_id) * 4096 + int'(info_next_id),
                    m_pv[s] * 4096 + m_nx[s]);
                chk("R6 random status", int'(info_status), m_st[s]);
            end
        end
        finish_run();
    end

endmodule